// File: doc/BRIEF.md
# DRAM CBR Refresh Scheduler with Power-Up Initialisation

This block keeps a DRAM's contents alive by issuing distributed CAS-before-RAS (CBR) refresh cycles at a fixed interval, and it brings the device out of power-up safely. In a CBR cycle the column strobe falls before the row strobe. The device then advances its own internal refresh row, so no address is driven and the data pins stay in high impedance. While the block owns the bus, the access controller must leave the address and data lines idle.

The block shares the strobes with an access controller through a request/grant handshake. After reset it holds off all traffic (`init_done` low) for a timed pause. It then runs a burst of initialisation refreshes. From then on an interval timer adds one owed refresh to a debt counter each period. Refreshes may be postponed while the controller is busy. The debt saturates, and an urgency flag rises once the debt reaches a threshold.

The state machine has five states:
- `ST_PAUSE` counts the start-up pause, then goes to `ST_IDLE`.
- `ST_IDLE` goes to `ST_CAS_LEAD` when a refresh is wanted and `bus_grant` is high.
- `ST_CAS_LEAD` holds CAS low alone, then goes to `ST_RAS_LOW`.
- `ST_RAS_LOW` holds both strobes low, then goes to `ST_PRECH`.
- `ST_PRECH` holds both strobes high for precharge, then returns to `ST_IDLE` and completes the refresh.

A refresh is wanted in every `ST_IDLE` cycle until initialisation is done. After that it is wanted whenever the debt is non-zero.

Top module: `dram_cbr_refresh`

## Requirements
- R1: In reset and in the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, and `refresh_req`, `init_done`, `ref_done`, `urgent` and `debt` are 0.
- R2: After reset is released, `refresh_req` stays 0 for exactly PAUSE_CYC clock edges and is 1 after edge number PAUSE_CYC.
- R3: Exactly INIT_REFRESHES CBR cycles run before `init_done` rises. `init_done` rises in the same cycle as the last of their `ref_done` pulses and then stays 1. `debt` stays 0 while `init_done` is 0.
- R4: In every refresh, `cas_n` is 0 for exactly CAS_LEAD_CYC cycles before `ras_n` falls. Both stay 0 for RAS_LOW_CYC cycles, and they return to 1 together.
- R5: After the strobes rise, both stay 1 for at least PRECH_CYC cycles before `cas_n` falls again. `ref_done` is a one-cycle pulse exactly PRECH_CYC cycles after the rise.
- R6: `we_n` is 1 whenever `ras_n` falls, so no refresh is taken as a write.
- R7: A refresh starts only after an edge where `refresh_req` and `bus_grant` are both 1. `refresh_req` stays 1 while either strobe is low. Once started, a refresh completes even if `bus_grant` drops.
- R8: After `init_done` rises, `debt` increases by one every INTERVAL_CYC cycles. The first increase is visible INTERVAL_CYC cycles after the first cycle with `init_done` = 1.
- R9: `debt` never exceeds DEBT_MAX. An interval that elapses at DEBT_MAX leaves it unchanged.
- R10: `urgent` is 1 exactly when `debt` >= URGENT_AT.
- R11: After initialisation, `refresh_req` is 1 in idle exactly when `debt` > 0. Each completed refresh lowers `debt` by one in the cycle of its `ref_done` pulse.
- R12: With `bus_grant` held at 1 after initialisation, successive falls of `ras_n` are exactly INTERVAL_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Access controller hands the strobes to this block |
| refresh_req | output | 1 | Block wants, or is using, the strobes |
| urgent | output | 1 | Debt has reached the urgency threshold |
| init_done | output | 1 | Power-up sequence finished; normal traffic allowed |
| ref_done | output | 1 | One-cycle pulse when a refresh cycle completes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| debt | output | $clog2(DEBT_MAX+1) | Number of owed refreshes |

## Verification
The bench builds the block with INTERVAL_CYC=40, PAUSE_CYC=50, INIT_REFRESHES=8, DEBT_MAX=4, URGENT_AT=3, CAS_LEAD_CYC=1, RAS_LOW_CYC=3 and PRECH_CYC=2. With these values a whole refresh takes six cycles, so the pause, the full initialisation burst, saturation of the debt and the urgency threshold are all reached within a few hundred cycles. The debt is sampled in the middle of every interval while the grant is withheld, and it is compared against min(k, DEBT_MAX). A strobe monitor measures every CAS lead, RAS width, precharge and `ref_done` offset against the parameters. The bench also covers a full drain of the saturated debt, the spacing of periodic refreshes, and a grant that is withdrawn in the middle of a cycle.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CAS_LEAD = 3'd2,
        ST_RAS_LOW  = 3'd3,
        ST_PRECH    = 3'd4
    } ref_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Timer stays parked at zero until it is enabled (R8)
    p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0) || $past(en));

endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
    parameter int DEBT_MAX  = 8,
    parameter int URGENT_AT = 6,
    parameter int DEBT_W    = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add,
    input  logic              sub,
    output logic [DEBT_W-1:0] debt,
    output logic              urgent
);
    localparam logic [DEBT_W-1:0] FULL = DEBT_W'(DEBT_MAX);
    localparam logic [DEBT_W-1:0] HOT  = DEBT_W'(URGENT_AT);

    logic do_add, do_sub;

    assign do_add = add && (debt != FULL);
    assign do_sub = sub && (debt != '0);
    assign urgent = (debt >= HOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else if (do_add && !do_sub) begin
            debt <= debt + 1'b1;
        end else if (do_sub && !do_add) begin
            debt <= debt - 1'b1;
        end
    end

    p_debt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= FULL);

    p_debt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !sub && debt != FULL) |=> debt == $past(debt) + 1'b1);

    p_debt_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sub && !add && debt != '0) |=> debt == $past(debt) - 1'b1);

endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import dram_ref_pkg::*;
#(
    parameter int PAUSE_CYC      = 40000,
    parameter int INIT_REFRESHES = 8,
    parameter int CAS_LEAD_CYC   = 1,
    parameter int RAS_LOW_CYC    = 12,
    parameter int PRECH_CYC      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic grant,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic req,
    output logic init_done,
    output logic done,
    output logic served
);
    localparam int MAXC = max_of(max_of(PAUSE_CYC, CAS_LEAD_CYC),
                                 max_of(RAS_LOW_CYC, PRECH_CYC));
    localparam int CW = $clog2(MAXC + 1);
    localparam int IW = $clog2(INIT_REFRESHES + 1);

    ref_state_t    state, state_nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] init_cnt;
    logic          periodic_q;
    logic          want, last, leaving;

    assign want = init_done ? pending : 1'b1;

    always_comb begin
        unique case (state)
            ST_PAUSE:    last = (cnt == CW'(PAUSE_CYC - 1));
            ST_CAS_LEAD: last = (cnt == CW'(CAS_LEAD_CYC - 1));
            ST_RAS_LOW:  last = (cnt == CW'(RAS_LOW_CYC - 1));
            ST_PRECH:    last = (cnt == CW'(PRECH_CYC - 1));
            default:     last = 1'b0;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PAUSE:    if (last) state_nxt = ST_IDLE;
            ST_IDLE:     if (want && grant) state_nxt = ST_CAS_LEAD;
            ST_CAS_LEAD: if (last) state_nxt = ST_RAS_LOW;
            ST_RAS_LOW:  if (last) state_nxt = ST_PRECH;
            ST_PRECH:    if (last) state_nxt = ST_IDLE;
            default:     state_nxt = ST_PAUSE;
        endcase
    end

    assign leaving = (state == ST_PRECH) && last;
    assign served  = leaving && periodic_q;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PAUSE;
            cnt        <= '0;
            init_cnt   <= '0;
            init_done  <= 1'b0;
            periodic_q <= 1'b0;
            done       <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= (state_nxt != state || state == ST_IDLE) ? '0 : cnt + 1'b1;
            done  <= leaving;
            if (state == ST_IDLE && state_nxt == ST_CAS_LEAD)
                periodic_q <= init_done;
            if (leaving && !init_done) begin
                init_cnt <= init_cnt + 1'b1;
                if (init_cnt == IW'(INIT_REFRESHES - 1))
                    init_done <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        req   = 1'b0;
        unique case (state)
            ST_PAUSE:    req = 1'b0;
            ST_IDLE:     req = want;
            ST_CAS_LEAD: begin cas_n = 1'b0; req = 1'b1; end
            ST_RAS_LOW:  begin cas_n = 1'b0; ras_n = 1'b0; req = 1'b1; end
            ST_PRECH:    req = 1'b1;
            default:     req = 1'b0;
        endcase
    end

    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    p_cas_covers_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    p_start_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(grant && req));

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n || !ras_n) |-> req);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh #(
    parameter int INTERVAL_CYC   = 3120,
    parameter int PAUSE_CYC      = 40000,
    parameter int INIT_REFRESHES = 8,
    parameter int DEBT_MAX       = 8,
    parameter int URGENT_AT      = 6,
    parameter int CAS_LEAD_CYC   = 1,
    parameter int RAS_LOW_CYC    = 12,
    parameter int PRECH_CYC      = 8,
    parameter int DEBT_W         = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    output logic              refresh_req,
    output logic              urgent,
    output logic              init_done,
    output logic              ref_done,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DEBT_W-1:0] debt
);
    logic tick, served;

    ref_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    ref_debt_counter #(
        .DEBT_MAX  (DEBT_MAX),
        .URGENT_AT (URGENT_AT),
        .DEBT_W    (DEBT_W)
    ) debt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .add    (tick),
        .sub    (served),
        .debt   (debt),
        .urgent (urgent)
    );

    cbr_sequencer #(
        .PAUSE_CYC      (PAUSE_CYC),
        .INIT_REFRESHES (INIT_REFRESHES),
        .CAS_LEAD_CYC   (CAS_LEAD_CYC),
        .RAS_LOW_CYC    (RAS_LOW_CYC),
        .PRECH_CYC      (PRECH_CYC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (debt != '0),
        .grant     (bus_grant),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .req       (refresh_req),
        .init_done (init_done),
        .done      (ref_done),
        .served    (served)
    );

    p_no_debt_before_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> debt == '0);

endmodule

// File: tb/dram_cbr_refresh_tb_top.sv
module dram_cbr_refresh_tb_top;
    localparam int INT  = 40;
    localparam int PAU  = 50;
    localparam int INIT = 8;
    localparam int DMAX = 4;
    localparam int URG  = 3;
    localparam int CASL = 1;
    localparam int RASL = 3;
    localparam int PRE  = 2;
    localparam int DW   = $clog2(DMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_grant = 1'b1;
    logic refresh_req, urgent, init_done, ref_done, ras_n, cas_n, we_n;
    logic [DW-1:0] debt;

    always #2.5 clk = ~clk;

    dram_cbr_refresh #(
        .INTERVAL_CYC (INT), .PAUSE_CYC (PAU), .INIT_REFRESHES (INIT),
        .DEBT_MAX (DMAX), .URGENT_AT (URG), .CAS_LEAD_CYC (CASL),
        .RAS_LOW_CYC (RASL), .PRECH_CYC (PRE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_grant (bus_grant),
        .refresh_req (refresh_req), .urgent (urgent), .init_done (init_done),
        .ref_done (ref_done), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .debt (debt)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe monitor
    int cyc = 0, ras_falls = 0, last_fall = 0, gap = 0;
    int lead_run = 0, low_run = 0, hi_run = 1000, since_rise = 1000;
    bit prev_ras = 1'b1, prev_cas = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 1'b1;
        end else begin
            cyc++;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                check(lead_run == CASL, "R4 cas lead", lead_run, CASL);
                check(we_n == 1'b1, "R6 we high", we_n, 1);
                check(refresh_req == 1'b1, "R7 req held", refresh_req, 1);
                gap = cyc - last_fall;
                last_fall = cyc;
            end
            if (!prev_ras && ras_n) begin
                check(low_run == RASL, "R4 ras width", low_run, RASL);
                check(cas_n == 1'b1, "R4 rise together", cas_n, 1);
                since_rise = 0;
            end
            if (prev_cas && !cas_n)
                check(hi_run >= PRE, "R5 precharge", hi_run, PRE);
            if (ref_done)
                check(since_rise == PRE, "R5 done offset", since_rise, PRE);
            lead_run   = (!cas_n && ras_n) ? lead_run + 1 : 0;
            low_run    = !ras_n ? low_run + 1 : 0;
            hi_run     = (cas_n && ras_n) ? hi_run + 1 : 0;
            since_rise = since_rise + 1;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes", {ras_n, cas_n, we_n}, 7);
        check(!refresh_req && !init_done && !ref_done && !urgent && debt == 0,
              "R1 flags", {refresh_req, init_done, ref_done, urgent}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && cas_n && !refresh_req && debt == 0, "R1 after release", refresh_req, 0);

        // R2 pause length (one edge already elapsed)
        n = 1;
        while (!refresh_req && n < 1000) begin @(negedge clk); n++; end
        check(n == PAU, "R2 pause", n, PAU);

        // R3 init burst
        while (!init_done) begin
            check(debt == 0, "R3 no debt before init", debt, 0);
            @(negedge clk);
        end
        check(ras_falls == INIT, "R3 init count", ras_falls, INIT);
        check(ref_done == 1'b1, "R3 init done with last pulse", ref_done, 1);

        // R8/R9/R10 debt accrual with grant withheld
        bus_grant = 1'b0;
        f0 = ras_falls;
        for (int k = 0; k <= 6; k++) begin
            repeat (INT / 2) @(negedge clk);
            begin
                int e;
                e = (k < DMAX) ? k : DMAX;
                check(debt == e, "R8 R9 debt level", debt, e);
                check(urgent == (e >= URG), "R10 urgent", urgent, (e >= URG));
                check(refresh_req == (e > 0), "R11 req in idle", refresh_req, (e > 0));
                check(init_done == 1'b1, "R3 sticky", init_done, 1);
            end
            repeat (INT - INT / 2) @(negedge clk);
        end
        check(ras_falls == f0, "R7 no refresh without grant", ras_falls - f0, 0);

        // R11 drain saturated debt: now at offset 0 of an interval, debt already full
        repeat (1) @(negedge clk);
        bus_grant = 1'b1;
        f0 = ras_falls;
        repeat (INT - 5) @(negedge clk);
        check(ras_falls - f0 == DMAX, "R11 drain count", ras_falls - f0, DMAX);
        check(debt == 0, "R11 drained", debt, 0);
        check(urgent == 1'b0 && refresh_req == 1'b0, "R10 R11 idle after drain", urgent, 0);

        // R12 periodic spacing
        for (int k = 0; k < 3; k++) begin
            f0 = ras_falls;
            while (ras_falls == f0) @(negedge clk);
            if (k > 0) check(gap == INT, "R12 spacing", gap, INT);
        end

        // R7 grant withdrawn mid-cycle
        while (ras_n) @(negedge clk);
        bus_grant = 1'b0;
        while (!ref_done) @(negedge clk);
        check(debt == 0, "R11 decrement on done", debt, 0);
        check(refresh_req == 1'b0, "R7 completes without grant", refresh_req, 0);
        f0 = ras_falls;
        repeat (INT + 2) @(negedge clk);
        check(debt == 1 && refresh_req == 1'b1, "R11 owed after interval", debt, 1);
        check(ras_falls == f0, "R7 held off", ras_falls - f0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule